// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block watches a processor heartbeat line and drives a dedicated active-low alarm when the processor stops toggling it. Any level change on the heartbeat, rising or falling, counts as a kick. The heartbeat is first brought into the clock domain through a two-flop synchroniser. The period counter advances only on a prescaled tick input, so both timeout lengths are parameters counted in ticks.

Each reset event returns the timer to a generous boot period. The first kick, or the expiry of that boot period, switches it to the short service period. Counting is held while the system reset or the manual reset is asserted. It restarts in boot mode on the cycle after a one-cycle release pulse from the external reset-timeout logic. An undervoltage-lockout flag pulls the alarm low for as long as it is present. Reset events and the return of the supplies release the alarm at once, with no stretch.

Feeding the alarm back into the manual-reset input is the integrator's choice and lives outside this block.

Top module: `hb_watchdog`

## Requirements
- R1: A rising edge and a falling edge of the heartbeat each count as a kick. A kick clears the period counter, so a heartbeat toggled at intervals shorter than the short period keeps the alarm high indefinitely.
- R2: After a release pulse, the first timeout used is the boot period of LONG_TICKS ticks. The alarm stays high through a gap longer than the short period as long as the gap is shorter than the boot period.
- R3: After the first kick following a release, the service period of SHORT_TICKS ticks applies.
- R4: The alarm (alarm_no = 0) asserts when the active period, counted in ticks, elapses with no kick. The latency from a heartbeat change to the counter clear is three clock cycles.
- R5: While sys_rst_i or mrst_i is high, the counter is cleared and held. The alarm is released high on the next clock. Counting stays held until rst_release_i is pulsed, and then resumes in boot mode.
- R6: While uvlo_i is high, alarm_no is low in the same cycle, without waiting for a clock. When uvlo_i falls, alarm_no returns high in the same cycle. The counter is held and waits for a release pulse.
- R7: Once asserted by an expiry, the alarm stays low regardless of heartbeat activity until sys_rst_i, mrst_i or uvlo_i is asserted.
- R8: A heartbeat pulse lasting a single clock cycle is detected as a kick.
- R9: The counter advances only in cycles where tick_i is high. With tick_i held low, no expiry occurs however long the heartbeat stays still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the logic |
| heartbeat_i | input | 1 | Processor heartbeat, asynchronous |
| sys_rst_i | input | 1 | System reset level, active high |
| rst_release_i | input | 1 | One-cycle pulse when the reset timeout ends |
| uvlo_i | input | 1 | Undervoltage-lockout flag, active high |
| mrst_i | input | 1 | Manual reset level, active high |
| tick_i | input | 1 | Prescaled tick enable |
| alarm_no | output | 1 | Watchdog alarm, active low |

## Verification
The hardest state to reach is the boot-to-service switch. The first kick must land after the boot period has started but before it expires, and only the first kick flips the mode. The stimulus therefore releases the timer, waits past the short period without kicking to show that boot mode is still active, and only then kicks and goes quiet, expecting the short expiry. Random episodes then vary the gaps between kicks. Each gap is drawn either clearly inside or clearly outside the service window, and sys_rst_i clears the timer between episodes.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic {
    MODE_BOOT    = 1'b0,
    MODE_SERVICE = 1'b1
  } wdg_mode_e;
endpackage

// File: rtl/hb_sync_edge.sv
module hb_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic edge_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], async_i};
  end

  // sh_q[1] is the newest synchronised sample and sh_q[2] the one before it
  assign edge_o = sh_q[1] ^ sh_q[2];
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int unsigned LONG_TICKS  = 1000,
  parameter int unsigned SHORT_TICKS = 100,
  localparam int unsigned CW = $clog2(LONG_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kick_i,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          release_i,
  output logic          expired_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);

  wdg_mode_e     mode_q;
  logic          run_q, exp_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_w;

  assign last_w = (mode_q == MODE_BOOT) ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_BOOT;
      run_q  <= 1'b0;
      exp_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (hold_i) begin
      mode_q <= MODE_BOOT;
      run_q  <= 1'b0;
      exp_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (release_i) begin
      mode_q <= MODE_BOOT;
      run_q  <= 1'b1;
      exp_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (run_q) begin
      if (kick_i) begin
        cnt_q  <= '0;
        mode_q <= MODE_SERVICE;
      end else if (tick_i) begin
        if (cnt_q == last_w) begin
          exp_q  <= 1'b1;
          run_q  <= 1'b0;
          mode_q <= MODE_SERVICE;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign expired_o = exp_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int unsigned LONG_TICKS  = 1000,
  parameter int unsigned SHORT_TICKS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic heartbeat_i,
  input  logic sys_rst_i,
  input  logic rst_release_i,
  input  logic uvlo_i,
  input  logic mrst_i,
  input  logic tick_i,
  output logic alarm_no
);
  localparam int unsigned CW = $clog2(LONG_TICKS + 1);

  logic          kick_w, expired_w, hold_w;
  logic [CW-1:0] cnt_w;

  assign hold_w = sys_rst_i | mrst_i | uvlo_i;

  hb_sync_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(heartbeat_i),
    .edge_o (kick_w)
  );

  wdg_counter #(
    .LONG_TICKS (LONG_TICKS),
    .SHORT_TICKS(SHORT_TICKS)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (kick_w),
    .tick_i   (tick_i),
    .hold_i   (hold_w),
    .release_i(rst_release_i),
    .expired_o(expired_w),
    .cnt_o    (cnt_w)
  );

  // lockout acts on the pin without a clock
  assign alarm_no = ~(uvlo_i | expired_w);
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int unsigned LONG_TICKS = 1000,
  parameter int unsigned CW         = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          sys_rst_i,
  input logic          mrst_i,
  input logic          uvlo_i,
  input logic          alarm_no,
  input logic          kick_i,
  input logic [CW-1:0] cnt_i
);
  p_kick_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> cnt_i == '0);

  p_fall_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(alarm_no) && !uvlo_i) |-> $past(tick_i));

  p_rst_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sys_rst_i || mrst_i) && !uvlo_i) |=> (alarm_no || uvlo_i));

  p_uvlo_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |-> !alarm_no);

  p_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_no) |-> $past(sys_rst_i || mrst_i || uvlo_i));

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < CW'(LONG_TICKS));
endmodule

bind hb_watchdog wdg_checker #(
  .LONG_TICKS(LONG_TICKS),
  .CW        (CW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .sys_rst_i(sys_rst_i),
  .mrst_i   (mrst_i),
  .uvlo_i   (uvlo_i),
  .alarm_no (alarm_no),
  .kick_i   (kick_w),
  .cnt_i    (cnt_w)
);

// File: tb/hb_watchdog_tb_top.sv
module hb_watchdog_tb_top;
  localparam int unsigned LONG  = 40;
  localparam int unsigned SHORT = 10;
  localparam int unsigned LAT   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hb = 1'b0, srst = 1'b0, rel = 1'b0, uvlo = 1'b0, mrst = 1'b0, tick = 1'b1;
  logic alarm_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hb_watchdog #(.LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .heartbeat_i(hb), .sys_rst_i(srst),
    .rst_release_i(rel), .uvlo_i(uvlo), .mrst_i(mrst), .tick_i(tick),
    .alarm_no(alarm_n)
  );

  // expected alarm after a quiet gap (in cycles, all ticking) since the last kick
  function automatic logic exp_after_gap(int gap, int period);
    return (gap >= period + LAT + 2) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(logic exp, string req);
    checks++;
    if (alarm_n !== exp) begin
      errors++;
      $display("FAIL %s: alarm_no=%b expected %b at %0t", req, alarm_n, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_pulse();
    rel = 1'b1; cyc(1); rel = 1'b0;
  endtask

  task automatic reset_event();
    srst = 1'b1; cyc(2); srst = 1'b0; release_pulse();
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    chk(1'b1, "R5 reset state");
    cyc(60);
    chk(1'b1, "R5 no count before release");

    // R2: boot period
    release_pulse();
    cyc(30);
    chk(1'b1, "R2 boot period still running");
    cyc(15);
    chk(1'b0, "R4 boot expiry");
    // R7: latched despite kicks
    for (int i = 0; i < 6; i++) begin hb = ~hb; cyc(4); end
    chk(1'b0, "R7 alarm latched");
    // R5: manual reset clears at once
    mrst = 1'b1; cyc(1);
    chk(1'b1, "R5 manual reset releases alarm");
    cyc(50); mrst = 1'b0; cyc(1);
    chk(1'b1, "R5 held while manual reset");

    // R3: first kick switches to service mode
    release_pulse();
    cyc(20);
    hb = ~hb;
    cyc(SHORT - 4);
    chk(1'b1, "R3 before service expiry");
    cyc(10);
    chk(1'b0, "R3 service expiry");

    // R1: alternating edges keep it alive
    reset_event();
    for (int i = 0; i < 20; i++) begin hb = ~hb; cyc(6); end
    chk(1'b1, "R1 both edge kinds kick");
    // R8: one-cycle pulses
    for (int i = 0; i < 20; i++) begin hb = ~hb; cyc(1); hb = ~hb; cyc(6); end
    chk(1'b1, "R8 single-cycle pulse kicks");
    // R9: no tick, no expiry
    tick = 1'b0; cyc(200);
    chk(1'b1, "R9 no count without tick");
    tick = 1'b1; cyc(SHORT + 6);
    chk(1'b0, "R9 counts once tick returns");

    // R6: lockout acts without clock
    @(posedge clk); #2;
    reset_event(); cyc(2);
    uvlo = 1'b1; #1;
    chk(1'b0, "R6 lockout asserts alarm");
    cyc(5); uvlo = 1'b0; #1;
    chk(1'b1, "R6 lockout release");
    cyc(60);
    chk(1'b1, "R6 held after lockout until release");

    // random episodes
    void'($urandom(32'h5eed));
    for (int ep = 0; ep < 40; ep++) begin
      int n_gap;
      reset_event();
      hb = ~hb; cyc(1);
      n_gap = 1 + ($urandom % 6);
      for (int g = 0; g < n_gap; g++) begin
        int gap;
        gap = ($urandom % 5 == 0) ? (SHORT + 8 + $urandom % 10) : (2 + $urandom % 5);
        cyc(gap);
        chk(exp_after_gap(gap, SHORT), "R4 random gap");
        if (alarm_n === 1'b0) break;
        hb = ~hb;
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule